// File: doc/BRIEF.md
# Dual-Processor Control and Interprocessor-Interrupt Register File

This block holds one byte-wide control register for each of the two processors in a two-processor system. It sits on a simple byte-addressed I/O bus with a write strobe and a combinational read path. Each control register drives the processor's reset line, its cache enable and a hold-off on its memory-bus grant. The register also carries a cache flush bit that works as a two-write sequence, a sticky coprocessor-error flag, a coprocessor-present strap bit, and a software-written interrupt bit with its own mask.

The interrupt bit gives interprocessor interrupts. Software on either processor sets the target's bit, and the 0-to-1 edge of that bit raises a one-cycle request towards the interrupt controller. If the target's mask bit is set at that moment, the edge is held and delivered once the mask clears. The first processor is always signalled on a fixed line number. For the second processor, the number comes from a separate vector register. The bus also offers an identity port, which tells the reading processor which of the two it is. A write to a relocation address invalidates both caches at once. Internal reset is asserted at once and released two clock edges after the external reset input deasserts.

Top module: `dual_cpu_ctl`

## Requirements
- R1: After reset, every writable bit of both control registers and the vector register is 0. All of cpu_rst, cache_en, bus_hold, cache_inv and ipi_req are 0, and ipi_vec0 reads 13. The first write is accepted on the third rising clock edge after rst_n rises.
- R2: The control register bit positions are: bit 0 reset, bit 1 coprocessor present (read-only, follows fpu_present), bit 2 cache on, bit 3 bus hold, bit 4 flush, bit 5 coprocessor error, bit 6 interrupt, bit 7 interrupt mask. The first processor's register is at 0x0040 and the second's at 0x0041. A write updates the bits, and a read returns them.
- R3: For the first processor, the reset, cache-on and bus-hold bits read 0 and ignore writes. cpu_rst[0], cache_en[0] and bus_hold[0] stay 0.
- R4: For the second processor, cpu_rst[1], cache_en[1] and bus_hold[1] equal control bits 0, 2 and 3 from the cycle after the write.
- R5: A write of 0 to the flush bit while it holds 1 produces a one-cycle pulse on that processor's cache_inv in the cycle after the write. A write of 0 while the flush bit already holds 0 produces none.
- R6: Any write to address 0x0044 pulses both cache_inv bits for one cycle in the cycle after the write.
- R7: Bit 5 is set in any cycle in which fpu_err of that processor is high. Writing 0 to bit 5 clears it. Writing 1 to bit 5 leaves it unchanged. A set from the error input wins over a clearing write in the same cycle.
- R8: A write that takes bit 6 from 0 to 1 while bit 7 is 0 raises ipi_req for exactly one cycle, two cycles after the write. Keeping bit 6 at 1 raises no further request.
- R9: A rising edge of bit 6 while bit 7 is 1 is held. It is delivered as a one-cycle ipi_req in the cycle after the write that clears bit 7, provided bit 6 is still 1. Clearing bit 6 first cancels the held edge.
- R10: The vector register at 0x0042 is read/write and drives ipi_vec1. ipi_vec0 is the constant 13.
- R11: The identity port at 0x0043 reads 0x00 when io_src is 0 and 0xF0 when io_src is 1. Writes to it have no effect.
- R12: Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Byte address of the access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_src | input | 1 | Accessing processor: 0 first, 1 second |
| io_rdata | output | 8 | Read data for io_addr (combinational) |
| fpu_present | input | 2 | Coprocessor-present straps, one per processor |
| fpu_err | input | 2 | Coprocessor error inputs, one per processor |
| cpu_rst | output | 2 | Processor reset outputs |
| cache_en | output | 2 | Cache enable outputs |
| bus_hold | output | 2 | Memory-bus grant inhibit outputs |
| cache_inv | output | 2 | One-cycle cache invalidate pulses |
| ipi_req | output | 2 | One-cycle interrupt requests |
| ipi_vec0 | output | 8 | Interrupt number for the first processor (fixed 13) |
| ipi_vec1 | output | 8 | Interrupt number for the second processor |

## Verification
The hardest situation to reach is a held interrupt edge that must either survive or be cancelled by the mask. Reaching it takes a set mask, then a 0-to-1 write of the interrupt bit, then a chosen order of clearing the mask and clearing the interrupt bit. One write that clears both bits together is also needed. The stimulus walks through each of these orders with idle cycles between them, so that a premature or a lost request shows up. A reference model in the bench predicts every output on every cycle. The same approach catches a flush pulse that fires on a 0-to-0 write, and an error flag cleared by a write of 1.

// File: rtl/dpc_pkg.sv
`timescale 1ns/1ps
package dpc_pkg;
  localparam int CTRL_W  = 8;
  localparam int B_RST   = 0;
  localparam int B_FPU   = 1;
  localparam int B_CACHE = 2;
  localparam int B_HOLD  = 3;
  localparam int B_FLUSH = 4;
  localparam int B_ERR   = 5;
  localparam int B_PINT  = 6;
  localparam int B_MASK  = 7;

  // packed from bit 7 down to bit 0
  typedef struct packed {
    logic mask;
    logic pint;
    logic err;
    logic flush;
    logic hold;
    logic cache;
    logic fpu;
    logic rst;
  } ctrl_t;
endpackage

// File: rtl/dpc_ipi_unit.sv
`timescale 1ns/1ps
module dpc_ipi_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic pint_i,
  input  logic mask_i,
  output logic ipi_req_o
);
  logic pint_d_q, pint_d_n;
  logic pend_q, pend_n;
  logic rise, fire;

  always_comb begin
    rise     = pint_i & ~pint_d_q;
    fire     = pend_q & ~mask_i & pint_i;
    pend_n   = pint_i & (rise | (pend_q & ~fire));
    pint_d_n = pint_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pint_d_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      pint_d_q <= pint_d_n;
      pend_q   <= pend_n;
    end
  end

  assign ipi_req_o = fire;

  // R9
  pend_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && mask_i && pint_i) |=> pend_q);

  // R8
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_req_o |=> !ipi_req_o);
endmodule

// File: rtl/dpc_cpu_ctrl.sv
`timescale 1ns/1ps
module dpc_cpu_ctrl
  import dpc_pkg::*;
#(
  parameter bit FULL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              reloc_wr_i,
  input  logic              fpu_present_i,
  input  logic              fpu_err_i,
  output logic [CTRL_W-1:0] ctrl_rd_o,
  output logic              cpu_rst_o,
  output logic              cache_en_o,
  output logic              bus_hold_o,
  output logic              cache_inv_o,
  output logic              ipi_req_o
);
  logic rst_q, rst_n2;
  logic cache_q, cache_n;
  logic hold_q, hold_n;
  logic flush_q, flush_n;
  logic err_q, err_n;
  logic pint_q, pint_n;
  logic mask_q, mask_n;
  logic inv_q, inv_n;
  ctrl_t rd;

  always_comb begin
    rst_n2  = rst_q;
    cache_n = cache_q;
    hold_n  = hold_q;
    flush_n = flush_q;
    err_n   = err_q;
    pint_n  = pint_q;
    mask_n  = mask_q;
    if (wr_i) begin
      flush_n = wdata_i[B_FLUSH];
      pint_n  = wdata_i[B_PINT];
      mask_n  = wdata_i[B_MASK];
      if (!wdata_i[B_ERR]) err_n = 1'b0;
      if (FULL) begin
        rst_n2  = wdata_i[B_RST];
        cache_n = wdata_i[B_CACHE];
        hold_n  = wdata_i[B_HOLD];
      end
    end
    if (fpu_err_i) err_n = 1'b1;
    inv_n = reloc_wr_i | (wr_i & flush_q & ~wdata_i[B_FLUSH]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= 1'b0;
      cache_q <= 1'b0;
      hold_q  <= 1'b0;
      flush_q <= 1'b0;
      err_q   <= 1'b0;
      pint_q  <= 1'b0;
      mask_q  <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      rst_q   <= rst_n2;
      cache_q <= cache_n;
      hold_q  <= hold_n;
      flush_q <= flush_n;
      err_q   <= err_n;
      pint_q  <= pint_n;
      mask_q  <= mask_n;
      inv_q   <= inv_n;
    end
  end

  always_comb begin
    rd.rst   = rst_q;
    rd.fpu   = fpu_present_i;
    rd.cache = cache_q;
    rd.hold  = hold_q;
    rd.flush = flush_q;
    rd.err   = err_q;
    rd.pint  = pint_q;
    rd.mask  = mask_q;
  end

  assign ctrl_rd_o   = rd;
  assign cpu_rst_o   = rst_q;
  assign cache_en_o  = cache_q;
  assign bus_hold_o  = hold_q;
  assign cache_inv_o = inv_q;

  dpc_ipi_unit u_ipi (
    .clk      (clk),
    .rst_n    (rst_n),
    .pint_i   (pint_q),
    .mask_i   (mask_q),
    .ipi_req_o(ipi_req_o)
  );

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fpu_err_i |=> ctrl_rd_o[B_ERR]);

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_i) |-> $stable(bus_hold_o));
endmodule

// File: rtl/dual_cpu_ctl.sv
`timescale 1ns/1ps
module dual_cpu_ctl
  import dpc_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] CTRL0_ADDR = 16'h0040,
  parameter logic [ADDR_W-1:0] CTRL1_ADDR = 16'h0041,
  parameter logic [ADDR_W-1:0] VEC1_ADDR  = 16'h0042,
  parameter logic [ADDR_W-1:0] ID_ADDR    = 16'h0043,
  parameter logic [ADDR_W-1:0] RELOC_ADDR = 16'h0044,
  parameter logic [CTRL_W-1:0] P0_LINE    = 8'd13,
  parameter logic [CTRL_W-1:0] P0_ID      = 8'h00,
  parameter logic [CTRL_W-1:0] P1_ID      = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [CTRL_W-1:0] io_wdata,
  input  logic              io_src,
  output logic [CTRL_W-1:0] io_rdata,
  input  logic [1:0]        fpu_present,
  input  logic [1:0]        fpu_err,
  output logic [1:0]        cpu_rst,
  output logic [1:0]        cache_en,
  output logic [1:0]        bus_hold,
  output logic [1:0]        cache_inv,
  output logic [1:0]        ipi_req,
  output logic [CTRL_W-1:0] ipi_vec0,
  output logic [CTRL_W-1:0] ipi_vec1
);
  localparam int NCPU = 2;

  logic [1:0]        sync_q;
  logic              rst_i;
  logic              reloc_wr;
  logic [CTRL_W-1:0] vec_q, vec_n;
  logic [CTRL_W-1:0] ctrl_rd [NCPU];
  logic [NCPU-1:0]   ctrl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_i = sync_q[1];

  assign reloc_wr = io_wr && (io_addr == RELOC_ADDR);

  genvar i;
  generate
    for (i = 0; i < NCPU; i++) begin : g_cpu
      localparam logic [ADDR_W-1:0] MY_ADDR = (i == 0) ? CTRL0_ADDR : CTRL1_ADDR;
      assign ctrl_wr[i] = io_wr && (io_addr == MY_ADDR);
      dpc_cpu_ctrl #(.FULL(i != 0)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_i),
        .wr_i         (ctrl_wr[i]),
        .wdata_i      (io_wdata),
        .reloc_wr_i   (reloc_wr),
        .fpu_present_i(fpu_present[i]),
        .fpu_err_i    (fpu_err[i]),
        .ctrl_rd_o    (ctrl_rd[i]),
        .cpu_rst_o    (cpu_rst[i]),
        .cache_en_o   (cache_en[i]),
        .bus_hold_o   (bus_hold[i]),
        .cache_inv_o  (cache_inv[i]),
        .ipi_req_o    (ipi_req[i])
      );
    end
  endgenerate

  always_comb begin
    vec_n = vec_q;
    if (io_wr && (io_addr == VEC1_ADDR)) vec_n = io_wdata;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) vec_q <= '0;
    else        vec_q <= vec_n;
  end

  always_comb begin
    io_rdata = '0;
    if (io_addr == CTRL0_ADDR)      io_rdata = ctrl_rd[0];
    else if (io_addr == CTRL1_ADDR) io_rdata = ctrl_rd[1];
    else if (io_addr == VEC1_ADDR)  io_rdata = vec_q;
    else if (io_addr == ID_ADDR)    io_rdata = io_src ? P1_ID : P0_ID;
  end

  assign ipi_vec0 = P0_LINE;
  assign ipi_vec1 = vec_q;

  // R5
  inv_cause_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (cache_inv != 2'b00) |-> $past(io_wr));

  // R6
  reloc_both_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $past(reloc_wr) |-> (cache_inv == 2'b11));
endmodule

// File: tb/dual_cpu_ctl_test.sv
`timescale 1ns/1ps
module dual_cpu_ctl_test;
  localparam logic [15:0] A_C0 = 16'h0040;
  localparam logic [15:0] A_C1 = 16'h0041;
  localparam logic [15:0] A_VEC = 16'h0042;
  localparam logic [15:0] A_ID = 16'h0043;
  localparam logic [15:0] A_REL = 16'h0044;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic io_wr = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic io_src = 1'b0;
  logic [7:0] io_rdata;
  logic [1:0] fpu_present = 2'b00;
  logic [1:0] fpu_err = 2'b00;
  logic [1:0] cpu_rst, cache_en, bus_hold, cache_inv, ipi_req;
  logic [7:0] ipi_vec0, ipi_vec1;

  dual_cpu_ctl uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_src(io_src), .io_rdata(io_rdata),
    .fpu_present(fpu_present), .fpu_err(fpu_err), .cpu_rst(cpu_rst),
    .cache_en(cache_en), .bus_hold(bus_hold), .cache_inv(cache_inv),
    .ipi_req(ipi_req), .ipi_vec0(ipi_vec0), .ipi_vec1(ipi_vec1)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int rcnt = 0;
  string phase = "R1";

  bit m_rst[2], m_cache[2], m_hold[2], m_flush[2], m_err[2];
  bit m_pint[2], m_pintd[2], m_pend[2], m_mask[2], m_inv[2];
  int m_vec = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d (phase %s)", cyc, phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input int got, input int exp, input string tag, input string nm);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s [phase %s] %s got %0h exp %0h", tag, phase, nm, got, exp);
    end
  endtask

  function automatic int exp_ctrl(input int c);
    return (int'(m_mask[c]) << 7) | (int'(m_pint[c]) << 6) | (int'(m_err[c]) << 5) |
           (int'(m_flush[c]) << 4) | (int'(m_hold[c]) << 3) | (int'(m_cache[c]) << 2) |
           (int'(fpu_present[c]) << 1) | int'(m_rst[c]);
  endfunction

  task automatic compare();
    int e;
    for (int c = 0; c < 2; c++) begin
      chk(cpu_rst[c], m_rst[c], (c == 0) ? "R3" : "R4", "cpu_rst");
      chk(cache_en[c], m_cache[c], (c == 0) ? "R3" : "R4", "cache_en");
      chk(bus_hold[c], m_hold[c], (c == 0) ? "R3" : "R4", "bus_hold");
      chk(cache_inv[c], m_inv[c], "R5", "cache_inv");
      chk(ipi_req[c], m_pend[c] && !m_mask[c] && m_pint[c], "R8", "ipi_req");
    end
    chk(ipi_vec0, 13, "R10", "ipi_vec0");
    chk(ipi_vec1, m_vec, "R10", "ipi_vec1");
    if (io_addr == A_C0)       chk(io_rdata, exp_ctrl(0), "R2", "rdata ctrl0");
    else if (io_addr == A_C1)  chk(io_rdata, exp_ctrl(1), "R2", "rdata ctrl1");
    else if (io_addr == A_VEC) chk(io_rdata, m_vec, "R10", "rdata vec");
    else if (io_addr == A_ID)  chk(io_rdata, io_src ? 8'hF0 : 8'h00, "R11", "rdata id");
    else begin
      e = 0;
      chk(io_rdata, e, "R12", "rdata other");
    end
  endtask

  task automatic tick();
    bit in_rst;
    bit n_rst[2], n_cache[2], n_hold[2], n_flush[2], n_err[2];
    bit n_pint[2], n_pintd[2], n_pend[2], n_mask[2], n_inv[2];
    int n_vec;
    bit wr, rise, fire;
    in_rst = !rst_n || (rcnt < 2);
    for (int c = 0; c < 2; c++) begin
      wr = io_wr && (io_addr == ((c == 0) ? A_C0 : A_C1));
      n_rst[c] = m_rst[c]; n_cache[c] = m_cache[c]; n_hold[c] = m_hold[c];
      n_flush[c] = m_flush[c]; n_pint[c] = m_pint[c]; n_mask[c] = m_mask[c];
      if (wr) begin
        n_flush[c] = io_wdata[4]; n_pint[c] = io_wdata[6]; n_mask[c] = io_wdata[7];
        if (c == 1) begin
          n_rst[c] = io_wdata[0]; n_cache[c] = io_wdata[2]; n_hold[c] = io_wdata[3];
        end
      end
      n_err[c] = fpu_err[c] || (m_err[c] && !(wr && !io_wdata[5]));
      n_inv[c] = (io_wr && io_addr == A_REL) || (wr && m_flush[c] && !io_wdata[4]);
      rise = m_pint[c] && !m_pintd[c];
      fire = m_pend[c] && !m_mask[c] && m_pint[c];
      n_pend[c] = m_pint[c] && (rise || (m_pend[c] && !fire));
      n_pintd[c] = m_pint[c];
      if (in_rst) begin
        n_rst[c] = 0; n_cache[c] = 0; n_hold[c] = 0; n_flush[c] = 0; n_err[c] = 0;
        n_pint[c] = 0; n_pintd[c] = 0; n_pend[c] = 0; n_mask[c] = 0; n_inv[c] = 0;
      end
    end
    n_vec = (io_wr && io_addr == A_VEC) ? int'(io_wdata) : m_vec;
    if (in_rst) n_vec = 0;
    if (rst_n && rcnt < 2) rcnt++;
    if (!rst_n) rcnt = 0;
    @(posedge clk);
    m_rst = n_rst; m_cache = n_cache; m_hold = n_hold; m_flush = n_flush; m_err = n_err;
    m_pint = n_pint; m_pintd = n_pintd; m_pend = n_pend; m_mask = n_mask; m_inv = n_inv;
    m_vec = n_vec;
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    tick();
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    io_addr = a;
    tick();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    // R1: reset state, then release
    phase = "R1";
    for (int k = 0; k < 3; k++) tick();
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    rd(A_C0); rd(A_C1); rd(A_VEC);

    // R2 / R3 / R4: layout, unimplemented bits on the first processor
    phase = "R2";
    fpu_present = 2'b10;
    rd(A_C0); rd(A_C1);
    fpu_present = 2'b01;
    rd(A_C0); rd(A_C1);
    phase = "R3";
    wr(A_C0, 8'h0D); rd(A_C0); idle(2);
    phase = "R4";
    wr(A_C1, 8'h0D); rd(A_C1); idle(2);
    wr(A_C1, 8'h04); rd(A_C1);
    wr(A_C1, 8'h00); rd(A_C1);

    // R5: flush sequence
    phase = "R5";
    wr(A_C0, 8'h10); rd(A_C0);
    wr(A_C0, 8'h00); rd(A_C0);
    wr(A_C0, 8'h00); idle(2);
    wr(A_C1, 8'h10); wr(A_C1, 8'h10); wr(A_C1, 8'h00); idle(2);

    // R6: relocation write flushes both
    phase = "R6";
    wr(A_REL, 8'h5A); idle(2);
    wr(A_REL, 8'h00); wr(A_REL, 8'hFF); idle(2);

    // R7: sticky error
    phase = "R7";
    fpu_err = 2'b01; tick(); fpu_err = 2'b00;
    rd(A_C0); idle(3);
    wr(A_C0, 8'h20); rd(A_C0);
    wr(A_C0, 8'h00); rd(A_C0);
    fpu_err = 2'b11;
    wr(A_C1, 8'h00);
    fpu_err = 2'b00;
    rd(A_C1);
    wr(A_C1, 8'h00); rd(A_C1);

    // R8: rising edge delivers one request
    phase = "R8";
    wr(A_C1, 8'h40); idle(5);
    wr(A_C1, 8'h40); idle(3);
    wr(A_C1, 8'h00); idle(2);
    wr(A_C0, 8'h40); idle(4);
    wr(A_C0, 8'h00); idle(2);

    // R9: masked edge held, delivered, or cancelled
    phase = "R9";
    wr(A_C0, 8'h80); wr(A_C0, 8'hC0); idle(5);
    wr(A_C0, 8'h40); idle(3);
    wr(A_C0, 8'h00); idle(2);
    wr(A_C1, 8'h80); wr(A_C1, 8'hC0); idle(3);
    wr(A_C1, 8'h80); idle(2);
    wr(A_C1, 8'h00); idle(3);
    wr(A_C1, 8'h80); wr(A_C1, 8'hC0); idle(2);
    wr(A_C1, 8'h00); idle(3);
    wr(A_C0, 8'h80); wr(A_C0, 8'hC0);
    wr(A_C0, 8'h00); wr(A_C0, 8'h40); idle(3);
    wr(A_C0, 8'h00); idle(2);

    // R10: vector register
    phase = "R10";
    wr(A_VEC, 8'h5A); rd(A_VEC);
    wr(A_VEC, 8'hA7); rd(A_VEC);

    // R11: identity port
    phase = "R11";
    io_src = 1'b0; rd(A_ID);
    io_src = 1'b1; rd(A_ID);
    wr(A_ID, 8'h33); rd(A_ID);
    io_src = 1'b0; rd(A_ID);
    rd(A_C0); rd(A_C1); rd(A_VEC);

    // R12: unmapped addresses
    phase = "R12";
    rd(16'h0099); rd(16'h0045); rd(16'hFFFF);
    idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule